// File: doc/BRIEF.md
# I2C Byte Master Engine

This block runs a single byte-sized transaction as an I2C bus master. A command is a set of request levels (begin with a START, transfer a byte in either direction, end with a STOP) plus the acknowledge level the master should return after a byte it reads. The engine walks through the requested pieces in a fixed order: the START condition, then eight data bits with the most significant bit first, then the acknowledge bit, then the STOP condition. It raises a one-cycle completion pulse when the last piece finishes. Each bit takes five phases, and each phase lasts `divider` system clocks.

Both bus lines are open-drain. For each line the block has an output that is always 0 and a release flag. A release flag of 0 means the block pulls that line low. Both lines are read back through a two-stage synchronizer. The block uses them for four things: to wait for a slave that holds SCL low, to sample data, to track whether the bus is busy between START and STOP, and to detect a lost arbitration. A controller above the engine holds the request levels until the completion pulse and then drops them.

Top module: `i2c_byte_master`

## Requirements
- R1: After synchronous reset, both release flags are 1 and done, bus_busy and arb_lost are 0.
- R2: A write command sends tx_byte most significant bit first, with SDA changing only while SCL is low. The SDA level sampled in the acknowledge bit is reported inverted on slave_ack, so slave_ack = 1 means the slave pulled SDA low.
- R3: A read command releases SDA for eight bits and presents the captured byte, first bit in the most significant position, on rx_byte. In the acknowledge bit the master places ack_level on SDA, where 0 means it pulls the line low.
- R4: With req_stop set, the command ends with SDA rising while SCL is high. Without req_stop, SCL stays low after completion.
- R5: done is high for exactly one cycle after the final phase of each command, and after an arbitration loss.
- R6: Without clock stretching and with divider of at least 4, consecutive SCL rising edges within a command are 5 × divider clocks apart.
- R7: While SCL is released but reads low, the current phase does not advance, so a slave that stretches the clock delays the transfer without corrupting it.
- R8: bus_busy becomes 1 after any START seen on the synchronized lines (SDA falls while SCL is high), including one from another master, and becomes 0 after a STOP (SDA rises while SCL is high).
- R9: If the master releases SDA to send a 1 in a data bit it drives (or a NACK) and samples it low while SCL is high, it sets arb_lost, releases both lines at once and pulses done.
- R10: A STOP seen on the bus while a command is active and not in its own STOP step sets arb_lost, releases both lines and pulses done.
- R11: While enable is 0, the block releases both lines, starts no command and raises no done.
- R12: arb_lost stays set until the next command begins, and is cleared when it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Core enable; 0 releases the bus |
| divider | input | 16 | System clocks per SCL phase |
| req_start | input | 1 | Begin the command with a START |
| req_stop | input | 1 | End the command with a STOP |
| req_read | input | 1 | Read one byte |
| req_write | input | 1 | Write one byte |
| ack_level | input | 1 | SDA level the master sends after a read byte |
| tx_byte | input | 8 | Byte to send |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_out | output | 1 | SCL drive value, always 0 |
| scl_hiz | output | 1 | 1 releases SCL, 0 pulls it low |
| sda_out | output | 1 | SDA drive value, always 0 |
| sda_hiz | output | 1 | 1 releases SDA, 0 pulls it low |
| rx_byte | output | 8 | Byte shifted in from the bus |
| slave_ack | output | 1 | 1 when SDA read low in the acknowledge bit |
| done | output | 1 | One-cycle completion pulse |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| arb_lost | output | 1 | Arbitration was lost in the last command |

## Verification
Several properties are checked on every cycle by the embedded assertions. The completion pulse never lasts two cycles. A disabled core releases both lines. Every rise of the arbitration flag comes with a completion pulse. bus_busy follows each detected START and STOP. A stretched SCL freezes the phase. Other behaviour only shows up in the bench's bus scenarios with a slave model: the bit order in both directions, the acknowledge levels, where STOP is placed, the SCL period, the delay caused by stretching, and arbitration loss through a forced SDA low or through a foreign STOP.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 16,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  input  logic             req_start,
  input  logic             req_stop,
  input  logic             req_read,
  input  logic             req_write,
  input  logic             ack_level,
  input  logic [NBITS-1:0] tx_byte,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_out,
  output logic             scl_hiz,
  output logic             sda_out,
  output logic             sda_hiz,
  output logic [NBITS-1:0] rx_byte,
  output logic             slave_ack,
  output logic             done,
  output logic             bus_busy,
  output logic             arb_lost
);
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_ACK, ST_STOP} step_t;

  step_t            step, after_step;
  logic [2:0]       phase;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_inc;
  logic [IDX_W-1:0] idx;
  logic [NBITS-1:0] shreg;
  logic             rd_q, xfer_q, stop_q, ack_q, smp;
  logic             scl_m, scl_s, sda_m, sda_s, sda_p;
  logic             scl_t, sda_t;

  assign scl_out = 1'b0;
  assign sda_out = 1'b0;
  assign rx_byte = shreg;

  wire start_det = scl_s & sda_p & ~sda_s;
  wire stop_det  = scl_s & ~sda_p & sda_s;
  wire stalled   = scl_hiz & ~scl_s;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  wire at_end    = cnt_inc >= {1'b0, divider};
  wire tick      = (step != ST_IDLE) & at_end & ~stalled;
  wire launch    = enable & (step == ST_IDLE) & ~done &
                   (req_start | req_stop | req_read | req_write);
  wire drive_one = ((step == ST_DATA) & ~rd_q & shreg[NBITS-1]) |
                   ((step == ST_ACK) & rd_q & ack_q);
  wire lost_sda  = tick & (phase == 3'd2) & drive_one & ~sda_s;
  wire lost_stop = stop_det & (step != ST_IDLE) & (step != ST_STOP);
  wire lost      = lost_sda | lost_stop;

  always_comb begin
    case (step)
      ST_START: after_step = xfer_q ? ST_DATA : (stop_q ? ST_STOP : ST_IDLE);
      ST_DATA:  after_step = (idx == '0) ? ST_ACK : ST_DATA;
      ST_ACK:   after_step = stop_q ? ST_STOP : ST_IDLE;
      default:  after_step = ST_IDLE;
    endcase
  end

  always_comb begin
    scl_t = scl_hiz;
    sda_t = sda_hiz;
    case (step)
      ST_START: begin
        scl_t = (phase == 3'd0) ? scl_hiz : (phase != 3'd4);
        sda_t = (phase < 3'd2);
      end
      ST_DATA: begin
        scl_t = phase inside {3'd1, 3'd2, 3'd3};
        sda_t = rd_q | shreg[NBITS-1];
      end
      ST_ACK: begin
        scl_t = phase inside {3'd1, 3'd2, 3'd3};
        sda_t = rd_q ? ack_q : 1'b1;
      end
      ST_STOP: begin
        scl_t = (phase != 3'd0);
        sda_t = (phase >= 3'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; scl_s <= 1'b1; sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
      step <= ST_IDLE; phase <= '0; cnt <= '0; idx <= '0; shreg <= '0;
      rd_q <= 1'b0; xfer_q <= 1'b0; stop_q <= 1'b0; ack_q <= 1'b0; smp <= 1'b0;
      scl_hiz <= 1'b1; sda_hiz <= 1'b1;
      slave_ack <= 1'b0; done <= 1'b0; bus_busy <= 1'b0; arb_lost <= 1'b0;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m;
      sda_m <= sda_in; sda_s <= sda_m; sda_p <= sda_s;
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
      done <= 1'b0;
      if (!enable) begin
        step <= ST_IDLE; phase <= '0; cnt <= '0;
        scl_hiz <= 1'b1; sda_hiz <= 1'b1;
      end else if (lost) begin
        step <= ST_IDLE; phase <= '0; cnt <= '0;
        scl_hiz <= 1'b1; sda_hiz <= 1'b1;
        done <= 1'b1; arb_lost <= 1'b1;
      end else if (launch) begin
        step   <= req_start ? ST_START : ((req_read | req_write) ? ST_DATA : ST_STOP);
        phase  <= '0; cnt <= '0;
        idx    <= IDX_W'(NBITS - 1);
        shreg  <= tx_byte;
        rd_q   <= req_read;
        xfer_q <= req_read | req_write;
        stop_q <= req_stop;
        ack_q  <= ack_level;
        arb_lost <= 1'b0;
      end else if (step != ST_IDLE) begin
        scl_hiz <= scl_t;
        sda_hiz <= sda_t;
        if (tick) begin
          cnt <= '0;
          if (phase == 3'd2) begin
            smp <= sda_s;
            if (step == ST_ACK) slave_ack <= ~sda_s;
          end
          if (phase == 3'd4) begin
            phase <= '0;
            if (step == ST_DATA) begin
              shreg <= {shreg[NBITS-2:0], smp};
              idx   <= idx - 1'b1;
            end
            step <= after_step;
            if (after_step == ST_IDLE) done <= 1'b1;
          end else begin
            phase <= phase + 3'd1;
          end
        end else if (!at_end) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_hiz && sda_hiz));

  // R9
  arb_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> done);

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> bus_busy);

  // R8
  busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !bus_busy);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && step != ST_IDLE && stalled && !lost) |=> $stable(phase));

endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] divider = 16'd8;
  logic        req_start = 0, req_stop = 0, req_read = 0, req_write = 0, ack_level = 0;
  logic [7:0]  tx_byte = 8'h00;
  logic        scl_out, scl_hiz, sda_out, sda_hiz, slave_ack, done, bus_busy, arb_lost;
  logic [7:0]  rx_byte;

  logic slv_scl_low = 1'b0, slv_sda_low = 1'b0, bench_sda_low = 1'b0;
  wire  scl_bus = (scl_hiz ? 1'b1 : scl_out) & ~slv_scl_low;
  wire  sda_bus = (sda_hiz ? 1'b1 : sda_out) & ~slv_sda_low & ~bench_sda_low;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst(rst), .enable(enable), .divider(divider),
    .req_start(req_start), .req_stop(req_stop), .req_read(req_read),
    .req_write(req_write), .ack_level(ack_level), .tx_byte(tx_byte),
    .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_out(scl_out), .scl_hiz(scl_hiz), .sda_out(sda_out), .sda_hiz(sda_hiz),
    .rx_byte(rx_byte), .slave_ack(slave_ack), .done(done),
    .bus_busy(bus_busy), .arb_lost(arb_lost)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor and slave model, acting away from the active edge
  logic       scl_p = 1'b1, sda_p = 1'b1;
  int         nstart = 0, nstop = 0, nrise = 0, nfall = 0, rise_last = 0, rise_prev = 0;
  logic       sl_armed = 0, sl_on = 0, sl_read = 0, sl_ack = 0, sl_done = 0, sl_ackseen = 0;
  logic [7:0] sl_tx = 0, sl_cap = 0;
  int         bcnt = 0, stretch_left = 0;
  logic       stretch_en = 0;

  always @(negedge clk) begin
    logic c_scl, c_sda;
    c_scl = scl_bus;
    c_sda = sda_bus;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) slv_scl_low = 1'b0;
    end
    if (c_scl && scl_p && sda_p && !c_sda) begin
      nstart++; bcnt = 0; sl_done = 0; sl_on = sl_armed; slv_sda_low = 1'b0;
    end
    if (c_scl && scl_p && !sda_p && c_sda) nstop++;
    if (c_scl && !scl_p) begin
      nrise++; rise_prev = rise_last; rise_last = cyc;
      if (sl_on) begin
        if (bcnt < 8) begin sl_cap = {sl_cap[6:0], c_sda}; bcnt++; end
        else begin sl_ackseen = c_sda; sl_done = 1'b1; end
      end
    end
    if (!c_scl && scl_p) begin
      nfall++;
      if (sl_on) begin
        if (sl_done) begin slv_sda_low = 1'b0; sl_on = 1'b0; end
        else if (bcnt < 8) slv_sda_low = sl_read & ~sl_tx[7-bcnt];
        else slv_sda_low = ~sl_read & sl_ack;
        if (stretch_en && bcnt == 3) begin
          slv_scl_low = 1'b1; stretch_left = 300; stretch_en = 1'b0;
        end
      end
    end
    scl_p = c_scl;
    sda_p = c_sda;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic sp, input logic rd, input logic wr,
                       input logic ack, input logic [7:0] data, input logic [15:0] dv);
    @(negedge clk);
    req_start = st; req_stop = sp; req_read = rd; req_write = wr;
    ack_level = ack; tx_byte = data; divider = dv;
  endtask

  task automatic wait_done(input int limit, output int took, output logic ok);
    took = 0; ok = 1'b0;
    while (took < limit && !ok) begin
      @(negedge clk);
      took++;
      if (done) ok = 1'b1;
    end
    req_start = 0; req_stop = 0; req_read = 0; req_write = 0;
  endtask

  // {start, stop, read, ack, data[7:0], div[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'd8},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'd6},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'd5},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'd4},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'd9},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'd7}
  };

  logic finished = 1'b0;
  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    int took, s0, f0, r0;
    logic ok, seen;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 scl_hiz", scl_hiz, 1);
    check("R1 sda_hiz", sda_hiz, 1);
    check("R1 done", done, 0);
    check("R1 bus_busy", bus_busy, 0);
    check("R1 arb_lost", arb_lost, 0);

    // R11: disabled core ignores a command
    issue(1, 1, 0, 1, 0, 8'h55, 16'd4);
    seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (done || !scl_hiz || !sda_hiz) seen = 1'b1;
    end
    check("R11 no activity while disabled", seen, 0);
    check("R11 no START on bus", nstart, 0);
    req_start = 0; req_stop = 0; req_write = 0;
    @(negedge clk);
    enable = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      sl_armed = 1; sl_read = v[17]; sl_tx = v[15:8]; sl_ack = v[16];
      s0 = nstop;
      issue(v[19], v[18], v[17], ~v[17], v[16], v[15:8], {8'd0, v[7:0]});
      wait_done(5000, took, ok);
      check("R5 done reached", ok, 1);
      if (v[17]) begin
        check("R3 rx_byte", rx_byte, v[15:8]);
        check("R3 master ack level", sl_ackseen, v[16]);
      end else begin
        check("R2 byte seen by slave", sl_cap, v[15:8]);
        check("R2 slave_ack", slave_ack, v[16]);
      end
      check("R6 scl period", rise_last - rise_prev, 5 * v[7:0]);
      @(negedge clk);
      check("R5 done one cycle", done, 0);
      if (v[18]) begin
        check("R4 stop generated", nstop - s0, 1);
        check("R8 busy cleared", bus_busy, 0);
      end else begin
        check("R4 scl held low", scl_bus, 0);
        check("R8 busy held", bus_busy, 1);
      end
      sl_armed = 0;
      repeat (3) @(negedge clk);
    end

    // R7: slave stretches SCL for 300 cycles
    sl_armed = 1; sl_read = 0; sl_ack = 1; stretch_en = 1;
    issue(1, 1, 0, 1, 0, 8'h96, 16'd8);
    wait_done(5000, took, ok);
    check("R7 done after stretch", ok, 1);
    check("R7 byte intact", sl_cap, 8'h96);
    check("R7 stretch delays", took >= 55 * 8 + 250, 1);
    sl_armed = 0;
    repeat (5) @(negedge clk);

    // R9: SDA forced low during a driven 1
    f0 = nfall;
    issue(1, 0, 0, 1, 0, 8'hFF, 16'd8);
    while (nfall < f0 + 3) @(negedge clk);
    bench_sda_low = 1'b1;
    wait_done(3000, took, ok);
    check("R9 done on loss", ok, 1);
    check("R9 arb_lost", arb_lost, 1);
    check("R9 lines released", {scl_hiz, sda_hiz}, 2'b11);
    bench_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 busy cleared by stop", bus_busy, 0);

    // R12: next command clears arb_lost
    sl_armed = 1; sl_read = 0; sl_ack = 1;
    issue(1, 1, 0, 1, 0, 8'h11, 16'd6);
    repeat (3) @(negedge clk);
    check("R12 arb_lost cleared", arb_lost, 0);
    wait_done(5000, took, ok);
    check("R12 command completes", sl_cap, 8'h11);
    sl_armed = 0;
    repeat (5) @(negedge clk);

    // R10: foreign STOP in a data bit
    r0 = nrise;
    issue(1, 0, 0, 1, 0, 8'hFF, 16'd16);
    while (nrise < r0 + 3) @(negedge clk);
    repeat (2) @(negedge clk);
    bench_sda_low = 1'b1;
    repeat (2) @(negedge clk);
    bench_sda_low = 1'b0;
    wait_done(3000, took, ok);
    check("R10 done on foreign stop", ok, 1);
    check("R10 arb_lost", arb_lost, 1);
    check("R10 lines released", {scl_hiz, sda_hiz}, 2'b11);
    repeat (10) @(negedge clk);

    // R8: START and STOP from another master while idle
    bench_sda_low = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 foreign start sets busy", bus_busy, 1);
    bench_sda_low = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 foreign stop clears busy", bus_busy, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule